// File: doc/BRIEF.md
# Requester-to-Domain Context Lookup

This block maps the 16-bit source identity of an incoming DMA request to the translation context of the protection domain that owns the device. The identity packs a bus number in its upper byte and a combined device/function number in its lower byte. It names the hardware function that issued the request and no other. The block resolves the identity in two chained reads through a simple memory port. The first read fetches a root-table entry selected by the bus number. The second read fetches a context-table entry selected by the device/function number. Either read can end the lookup with a fault when the fetched entry is not marked valid.

A request is taken on a valid/ready handshake. Only one lookup is in flight at a time: `req_ready_o` stays low from acceptance until the result has been taken on its own valid/ready handshake. A result carries a fault flag, the domain number, the page-table root pointer, the page-walk depth and a flag that says whether the device may send already-translated requests. A small fully associative cache holds recently resolved contexts. A hit answers without touching memory. Software-driven invalidation removes cached contexts globally, by domain, or by requester.

The controller has six states. IDLE accepts a request and goes to DONE on a cache hit or to ROOT_REQ on a miss. ROOT_REQ holds the root read until it is taken and then goes to ROOT_WAIT. ROOT_WAIT goes to CTX_REQ when the root entry is valid and to DONE with a fault when it is not. CTX_REQ holds the context read until it is taken and then goes to CTX_WAIT. CTX_WAIT goes to DONE when the response arrives. DONE presents the result and returns to IDLE once it is accepted.

Top module: `ctx_lookup`

## Requirements
- R1: While reset is asserted and on leaving it, `req_ready_o` is 1 and both `res_valid_o` and `mem_req_valid_o` are 0.
- R2: On a cache miss, the first memory read is at address `{root_base_i[ADDR_W-1:12], rid[15:8], 4'h0}`.
- R3: A root entry with bit 0 clear ends the lookup with `res_fault_o`=1 and no second memory read.
- R4: When the root entry has bit 0 set, the second read is at `{root_entry[ADDR_W-1:12], rid[7:0], 4'h0}`.
- R5: A context entry with bit 0 clear gives a result with `res_fault_o`=1.
- R6: A context entry with bit 0 set gives a result with `res_fault_o`=0. The domain is taken from entry bits [87:72]. The page-table root is entry bits [ADDR_W-1:12] with 12 zero low bits. The walk depth is taken from bits [66:64] and the translated-request permission from bit 1.
- R7: `req_ready_o` is 0 from acceptance until the result is taken, and the result stays valid and unchanged while `res_ready_i` is 0.
- R8: A memory read request keeps `mem_req_valid_o` high and its address unchanged until `mem_req_ready_i` is high.
- R9: A requester resolved without fault is found in the cache on its next lookup. The result is valid in the cycle after acceptance and no memory read is made.
- R10: Faulted lookups are not cached, so repeating one walks memory again.
- R11: An invalidation with kind 1 (all) empties the cache.
- R12: An invalidation with kind 2 removes only cached contexts whose domain equals `inv_domain_i`.
- R13: An invalidation with kind 3 removes only the context of `inv_rid_i`, and kind 0 changes nothing.
- R14: A context fetched by a walk during which any invalidation arrived is returned but not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base_i | input | ADDR_W | Root-table base, 4 KB aligned |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request ready |
| req_rid_i | input | 16 | Requester identity {bus, devfn} |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory read request taken |
| mem_req_addr_o | output | ADDR_W | Memory read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 128 | 16-byte table entry |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result taken |
| res_fault_o | output | 1 | Lookup faulted |
| res_domain_o | output | 16 | Domain number |
| res_ptroot_o | output | ADDR_W | Page-table root pointer |
| res_levels_o | output | 3 | Page-walk depth |
| res_xlat_ok_o | output | 1 | Translated requests permitted |
| inv_valid_i | input | 1 | Invalidation strobe |
| inv_kind_i | input | 2 | 0 none, 1 all, 2 by domain, 3 by requester |
| inv_domain_i | input | 16 | Domain for kind 2 |
| inv_rid_i | input | 16 | Requester for kind 3 |

## Verification
The lookup is exercised with requesters whose root entry is absent, whose context entry is absent, and that resolve fully. The count and addresses of the memory reads show which of these paths the controller took. Each requester is tried twice so that cache hits, which take one cycle and make no read, can be told apart from faulted identities that must walk again. Memory stalls of different lengths show whether the read address is held steady. Invalidations by all, by domain, by requester and of kind none are followed by lookups of both targeted and untouched requesters, so that too-broad and too-narrow flushes show up. An invalidation pulsed in the middle of a walk shows whether the walk's fill is suppressed.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROOT_REQ,
        S_ROOT_WAIT,
        S_CTX_REQ,
        S_CTX_WAIT,
        S_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        INV_NONE = 2'd0,
        INV_ALL  = 2'd1,
        INV_DOM  = 2'd2,
        INV_RID  = 2'd3
    } inv_kind_t;

    typedef struct packed {
        logic [15:0] domain;
        logic [2:0]  levels;
        logic        xok;
    } ctx_meta_t;

    localparam int ENTRY_W = 128;

endpackage

// File: rtl/ctx_entry_decode.sv
module ctx_entry_decode
    import ctx_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ENTRY_W-1:0] entry_i,
    output logic               present_o,
    output logic [ADDR_W-13:0] ptr_o,
    output ctx_meta_t          meta_o
);
    localparam int PTR_W = ADDR_W - 12;

    always_comb begin
        present_o     = entry_i[0];
        ptr_o         = entry_i[ADDR_W-1:12];
        meta_o.xok    = entry_i[1];
        meta_o.levels = entry_i[66:64];
        meta_o.domain = entry_i[87:72];
    end

    logic unused_bits;
    assign unused_bits = ^{entry_i[ENTRY_W-1:88], entry_i[71:67], entry_i[63:ADDR_W],
                           entry_i[11:2], PTR_W[0]};

endmodule

// File: rtl/ctx_cache.sv
module ctx_cache
    import ctx_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        lk_rid_i,
    output logic               lk_hit_o,
    output ctx_meta_t          lk_meta_o,
    output logic [ADDR_W-13:0] lk_ptr_o,
    input  logic               fill_i,
    input  logic [15:0]        fill_rid_i,
    input  ctx_meta_t          fill_meta_i,
    input  logic [ADDR_W-13:0] fill_ptr_i,
    input  logic               inv_valid_i,
    input  inv_kind_t          inv_kind_i,
    input  logic [15:0]        inv_domain_i,
    input  logic [15:0]        inv_rid_i
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]  valid_q;
    logic [15:0]         tag_q  [ENTRIES];
    ctx_meta_t           meta_q [ENTRIES];
    logic [ADDR_W-13:0]  ptr_q  [ENTRIES];
    logic [IDX_W-1:0]    rr_q;
    logic [ENTRIES-1:0]  hit_vec;
    logic [ENTRIES-1:0]  kill_vec;
    logic [IDX_W-1:0]    victim;
    logic                have_free;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_way
        assign hit_vec[g]  = valid_q[g] && (tag_q[g] == lk_rid_i);
        assign kill_vec[g] = inv_valid_i && (
                               (inv_kind_i == INV_ALL) ||
                               ((inv_kind_i == INV_DOM) && (meta_q[g].domain == inv_domain_i)) ||
                               ((inv_kind_i == INV_RID) && (tag_q[g] == inv_rid_i)));
    end

    always_comb begin
        lk_meta_o = '0;
        lk_ptr_o  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                lk_meta_o = lk_meta_o | meta_q[i];
                lk_ptr_o  = lk_ptr_o  | ptr_q[i];
            end
        end
        lk_hit_o = |hit_vec;
    end

    always_comb begin
        have_free = 1'b0;
        victim    = rr_q;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                have_free = 1'b1;
                victim    = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                meta_q[i] <= '0;
                ptr_q[i]  <= '0;
            end
        end else begin
            valid_q <= valid_q & ~kill_vec;
            if (fill_i) begin
                valid_q[victim] <= 1'b1;
                tag_q[victim]   <= fill_rid_i;
                meta_q[victim]  <= fill_meta_i;
                ptr_q[victim]   <= fill_ptr_i;
                if (!have_free) begin
                    rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
                end
            end
        end
    end

    // R9
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));

endmodule

// File: rtl/ctx_lookup.sv
module ctx_lookup
    import ctx_pkg::*;
#(
    parameter int ADDR_W        = 48,
    parameter int CACHE_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [15:0]       req_rid_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [127:0]      mem_rsp_data_i,
    output logic              res_valid_o,
    input  logic              res_ready_i,
    output logic              res_fault_o,
    output logic [15:0]       res_domain_o,
    output logic [ADDR_W-1:0] res_ptroot_o,
    output logic [2:0]        res_levels_o,
    output logic              res_xlat_ok_o,
    input  logic              inv_valid_i,
    input  logic [1:0]        inv_kind_i,
    input  logic [15:0]       inv_domain_i,
    input  logic [15:0]       inv_rid_i
);
    localparam int PTR_W = ADDR_W - 12;

    walk_state_t       state_q, state_d;
    logic [15:0]       rid_q;
    logic [PTR_W-1:0]  ctp_q;
    logic              inv_seen_q;
    logic              fault_q;
    ctx_meta_t         meta_q;
    logic [PTR_W-1:0]  ptr_q;

    logic              c_hit;
    ctx_meta_t         c_meta;
    logic [PTR_W-1:0]  c_ptr;
    logic              d_present;
    logic [PTR_W-1:0]  d_ptr;
    ctx_meta_t         d_meta;
    logic              fill;
    logic              unused_base;

    assign unused_base = ^root_base_i[11:0];

    ctx_entry_decode #(.ADDR_W(ADDR_W)) u_decode (
        .entry_i   (mem_rsp_data_i),
        .present_o (d_present),
        .ptr_o     (d_ptr),
        .meta_o    (d_meta)
    );

    assign fill = (state_q == S_CTX_WAIT) && mem_rsp_valid_i && d_present
                  && !inv_seen_q && !inv_valid_i;

    ctx_cache #(.ENTRIES(CACHE_ENTRIES), .ADDR_W(ADDR_W)) u_cache (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_rid_i     (req_rid_i),
        .lk_hit_o     (c_hit),
        .lk_meta_o    (c_meta),
        .lk_ptr_o     (c_ptr),
        .fill_i       (fill),
        .fill_rid_i   (rid_q),
        .fill_meta_i  (d_meta),
        .fill_ptr_i   (d_ptr),
        .inv_valid_i  (inv_valid_i),
        .inv_kind_i   (inv_kind_t'(inv_kind_i)),
        .inv_domain_i (inv_domain_i),
        .inv_rid_i    (inv_rid_i)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (req_valid_i)     state_d = c_hit ? S_DONE : S_ROOT_REQ;
            S_ROOT_REQ:  if (mem_req_ready_i) state_d = S_ROOT_WAIT;
            S_ROOT_WAIT: if (mem_rsp_valid_i) state_d = d_present ? S_CTX_REQ : S_DONE;
            S_CTX_REQ:   if (mem_req_ready_i) state_d = S_CTX_WAIT;
            S_CTX_WAIT:  if (mem_rsp_valid_i) state_d = S_DONE;
            S_DONE:      if (res_ready_i)     state_d = S_IDLE;
            default:                          state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rid_q      <= '0;
            ctp_q      <= '0;
            inv_seen_q <= 1'b0;
            fault_q    <= 1'b0;
            meta_q     <= '0;
            ptr_q      <= '0;
        end else begin
            if (state_q == S_IDLE) begin
                if (req_valid_i) begin
                    rid_q      <= req_rid_i;
                    inv_seen_q <= 1'b0;
                    fault_q    <= 1'b0;
                    meta_q     <= c_meta;
                    ptr_q      <= c_ptr;
                end
            end else if (inv_valid_i) begin
                inv_seen_q <= 1'b1;
            end
            if (state_q == S_ROOT_WAIT && mem_rsp_valid_i) begin
                ctp_q <= d_ptr;
                if (!d_present) begin
                    fault_q <= 1'b1;
                    meta_q  <= '0;
                    ptr_q   <= '0;
                end
            end
            if (state_q == S_CTX_WAIT && mem_rsp_valid_i) begin
                fault_q <= !d_present;
                meta_q  <= d_present ? d_meta : '0;
                ptr_q   <= d_present ? d_ptr  : '0;
            end
        end
    end

    always_comb begin
        req_ready_o     = (state_q == S_IDLE);
        mem_req_valid_o = (state_q == S_ROOT_REQ) || (state_q == S_CTX_REQ);
        res_valid_o     = (state_q == S_DONE);
        unique case (state_q)
            S_ROOT_REQ: mem_req_addr_o = {root_base_i[ADDR_W-1:12], rid_q[15:8], 4'h0};
            S_CTX_REQ:  mem_req_addr_o = {ctp_q, rid_q[7:0], 4'h0};
            default:    mem_req_addr_o = '0;
        endcase
        res_fault_o   = fault_q;
        res_domain_o  = meta_q.domain;
        res_levels_o  = meta_q.levels;
        res_xlat_ok_o = meta_q.xok;
        res_ptroot_o  = {ptr_q, 12'h000};
    end

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable({res_fault_o, res_domain_o,
                                            res_ptroot_o, res_levels_o, res_xlat_ok_o})));

    // R9
    hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && c_hit) |=> (res_valid_o && !mem_req_valid_o));

    // R3
    root_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_ROOT_WAIT) && mem_rsp_valid_i && !d_present) |=> (res_valid_o && res_fault_o));

endmodule

// File: tb/ctx_lookup_bench.sv
module ctx_lookup_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 48;
    localparam logic [AW-1:0] ROOT_BASE = 48'h0000_0010_0000;
    localparam int NVEC = 10;
    // {rid, expected memory reads}
    localparam logic [17:0] VECS [NVEC] = '{
        {16'h0108, 2'd2}, {16'h0500, 2'd1}, {16'h0213, 2'd2}, {16'h0108, 2'd0},
        {16'h0500, 2'd1}, {16'h0213, 2'd2}, {16'h0209, 2'd2}, {16'h020A, 2'd2},
        {16'h0209, 2'd0}, {16'h0300, 2'd2}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_ready;
    logic [15:0] req_rid = '0;
    logic mem_req_valid, mem_req_ready = 0;
    logic [AW-1:0] mem_req_addr;
    logic mem_rsp_valid = 0;
    logic [127:0] mem_rsp_data = '0;
    logic res_valid, res_ready = 0, res_fault, res_xok;
    logic [15:0] res_domain;
    logic [AW-1:0] res_ptroot;
    logic [2:0] res_levels;
    logic inv_valid = 0;
    logic [1:0] inv_kind = 0;
    logic [15:0] inv_domain = 0, inv_rid = 0;

    int tests = 0, fails = 0;
    int stall_len = 0, rd_n = 0, stable_err = 0;
    logic [AW-1:0] a0, a1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_lookup u_ctx_lookup (
        .clk(clk), .rst_n(rst_n), .root_base_i(ROOT_BASE),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_rid_i(req_rid),
        .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
        .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
        .mem_rsp_data_i(mem_rsp_data), .res_valid_o(res_valid), .res_ready_i(res_ready),
        .res_fault_o(res_fault), .res_domain_o(res_domain), .res_ptroot_o(res_ptroot),
        .res_levels_o(res_levels), .res_xlat_ok_o(res_xok), .inv_valid_i(inv_valid),
        .inv_kind_i(inv_kind), .inv_domain_i(inv_domain), .inv_rid_i(inv_rid)
    );

    function automatic logic root_ok(input logic [7:0] bus);  return bus != 8'h05; endfunction
    function automatic logic ctx_ok(input logic [7:0] devfn); return devfn != 8'h13; endfunction
    function automatic logic [AW-1:0] ctp_of(input logic [7:0] bus);
        return 48'h0000_0020_0000 + {28'h0, bus, 12'h000};
    endfunction
    function automatic logic [AW-1:0] pt_of(input logic [15:0] rid);
        return 48'h3000_0000_0000 | {16'h0, rid, 12'h000};
    endfunction
    function automatic logic [2:0] lv_of(input logic [7:0] devfn);
        return {1'b0, devfn[1:0]} + 3'd2;
    endfunction

    function automatic logic [127:0] mem_data(input logic [AW-1:0] addr);
        logic [127:0] d = '0;
        logic [7:0] bus, devfn;
        if (addr[AW-1:12] == ROOT_BASE[AW-1:12]) begin
            bus = addr[11:4];
            d[AW-1:12] = ctp_of(bus) >> 12;
            d[0] = root_ok(bus);
            d[127:120] = 8'hA5;
        end else if (addr[AW-1:20] == 28'h2) begin
            bus = addr[19:12];
            devfn = addr[11:4];
            d[0] = ctx_ok(devfn);
            d[1] = devfn[0];
            d[AW-1:12] = pt_of({bus, devfn}) >> 12;
            d[66:64] = lv_of(devfn);
            d[87:72] = {8'h00, bus};
            d[127:120] = 8'h5A;
        end
        return d;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder
    initial begin : responder
        logic pend = 0;
        int wcnt = 0;
        logic [AW-1:0] paddr = '0, saddr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (pend) begin
                mem_rsp_valid = 1;
                mem_rsp_data = mem_data(paddr);
                pend = 0;
            end
            mem_req_ready = 0;
            if (mem_req_valid) begin
                if (wcnt > 0 && mem_req_addr != saddr) stable_err++;
                if (wcnt < stall_len) begin
                    if (wcnt == 0) saddr = mem_req_addr;
                    wcnt++;
                end else begin
                    mem_req_ready = 1;
                    paddr = mem_req_addr;
                    pend = 1;
                    if (rd_n == 0) a0 = mem_req_addr; else a1 = mem_req_addr;
                    rd_n++;
                    wcnt = 0;
                end
            end
        end
    end

    task automatic do_lookup(input logic [15:0] rid, input int stall, input int exp_reads,
                             input bit inv_mid, input string tag);
        int lat;
        bit bp_err = 0;
        logic efault;
        logic [63:0] snap;
        stall_len = stall;
        rd_n = 0;
        @(negedge clk);
        check(req_ready, {tag, " R7 ready before accept"}, req_ready, 1);
        req_valid = 1; req_rid = rid;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!res_valid && lat < 300) begin
            if (req_ready) bp_err = 1;
            if (inv_mid && lat == 2) begin
                inv_valid = 1; inv_kind = 2'd3; inv_rid = 16'h0777;
            end else inv_valid = 0;
            @(negedge clk);
            lat++;
        end
        inv_valid = 0;
        if (req_ready) bp_err = 1;
        check(!bp_err, {tag, " R7 ready low while busy"}, bp_err, 0);
        efault = !root_ok(rid[15:8]) || !ctx_ok(rid[7:0]);
        check(res_valid, {tag, " result valid"}, res_valid, 1);
        check(rd_n == exp_reads, {tag, " R3 R9 R10 read count"}, rd_n, exp_reads);
        check(res_fault == efault, {tag, " R3 R5 fault"}, res_fault, efault);
        if (exp_reads >= 1)
            check(a0 == {ROOT_BASE[AW-1:12], rid[15:8], 4'h0}, {tag, " R2 root addr"},
                  a0, {ROOT_BASE[AW-1:12], rid[15:8], 4'h0});
        if (exp_reads == 2)
            check(a1 == (ctp_of(rid[15:8]) | {rid[7:0], 4'h0}), {tag, " R4 ctx addr"},
                  a1, ctp_of(rid[15:8]) | {rid[7:0], 4'h0});
        if (exp_reads == 0)
            check(lat == 1, {tag, " R9 hit latency"}, lat, 1);
        if (!efault) begin
            check(res_domain == {8'h00, rid[15:8]}, {tag, " R6 domain"}, res_domain, {8'h00, rid[15:8]});
            check(res_ptroot == pt_of(rid), {tag, " R6 ptroot"}, res_ptroot, pt_of(rid));
            check(res_levels == lv_of(rid[7:0]), {tag, " R6 levels"}, res_levels, lv_of(rid[7:0]));
            check(res_xok == rid[0], {tag, " R6 xlat"}, res_xok, rid[0]);
        end
        snap = {res_fault, res_xok, res_levels, res_domain, res_ptroot[42:0]};
        @(negedge clk);
        check(res_valid && snap == {res_fault, res_xok, res_levels, res_domain, res_ptroot[42:0]},
              {tag, " R7 result held"}, {res_fault, res_xok, res_levels, res_domain, res_ptroot[42:0]}, snap);
        res_ready = 1;
        @(negedge clk);
        res_ready = 0;
        check(req_ready && !res_valid, {tag, " R7 idle after take"}, {req_ready, res_valid}, 2'b10);
    endtask

    task automatic invalidate(input logic [1:0] kind, input logic [15:0] dom, input logic [15:0] rid);
        @(negedge clk);
        inv_valid = 1; inv_kind = kind; inv_domain = dom; inv_rid = rid;
        @(negedge clk);
        inv_valid = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(req_ready && !res_valid && !mem_req_valid, "R1 in reset",
              {req_ready, res_valid, mem_req_valid}, 3'b100);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !res_valid && !mem_req_valid, "R1 after reset",
              {req_ready, res_valid, mem_req_valid}, 3'b100);

        for (int i = 0; i < NVEC; i++)
            do_lookup(VECS[i][17:2], i % 3, int'(VECS[i][1:0]), 0, $sformatf("vec%0d", i));

        // cache now holds 0108 0209 020A 0300
        invalidate(2'd1, 16'h0, 16'h0);                       // R11
        do_lookup(16'h0108, 0, 2, 0, "R11 after global");
        do_lookup(16'h0209, 1, 2, 0, "R11 refill a");
        do_lookup(16'h020A, 0, 2, 0, "R11 refill b");
        do_lookup(16'h0300, 2, 2, 0, "R11 refill c");

        invalidate(2'd2, 16'h0002, 16'h0);                    // R12
        do_lookup(16'h0108, 0, 0, 0, "R12 other domain kept");
        do_lookup(16'h0300, 0, 0, 0, "R12 other domain kept2");
        do_lookup(16'h0209, 0, 2, 0, "R12 domain removed");
        do_lookup(16'h020A, 0, 2, 0, "R12 domain removed2");

        invalidate(2'd3, 16'h0, 16'h0300);                    // R13
        do_lookup(16'h0108, 0, 0, 0, "R13 other rid kept");
        do_lookup(16'h0300, 0, 2, 0, "R13 rid removed");
        invalidate(2'd0, 16'h0001, 16'h0108);                 // R13 kind none
        do_lookup(16'h0108, 0, 0, 0, "R13 kind none");
        do_lookup(16'h020A, 0, 0, 0, "R13 kind none b");

        invalidate(2'd1, 16'h0, 16'h0);                       // R14
        do_lookup(16'h0140, 3, 2, 1, "R14 walk with inv");
        do_lookup(16'h0140, 0, 2, 0, "R14 not cached");
        do_lookup(16'h0140, 0, 0, 0, "R14 cached later");

        check(stable_err == 0, "R8 stalled address stable", stable_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule